// File: doc/BRIEF.md
# External Bus Mode Arbitration Controller

This block decides how an external-bus interface shares the bus with at most one other master. Three configuration inputs pick one of four operating modes. The first is a disable bit, the second enables an external master, and the third chooses where the arbiter lives. When the block is disabled it grants nothing. In parked single-master mode it serves internal requests at once, ignores the request, grant and busy pins, and flags those pins as free for another function.

With the external master enabled, the block shares the bus in one of two ways. When the arbiter-select bit is 0, the block acts as system master and arbitrates itself: it grants the other master when that master requests an idle bus. When the bit is 1, an outside arbiter decides and the block is the system slave: it raises a request, waits for a grant on an idle bus, and drives busy for the whole of its own transfer. In both dual-master modes, a period in which the other master holds the bus is reported as an acknowledged external access into internal space.

The mode is re-sampled only while the controller is idle. A configuration change therefore never cuts off a transfer that is already running.

Top module: `ebarb_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, all outputs go to 0 except `pins_free_o`, which goes to 1. The controller returns to idle in disabled mode.
- R2: With `mode_off_i`=1, no grant, busy, request or external acknowledge is ever produced, whatever the other inputs do, and `pins_free_o` is 1.
- R3: In parked mode (`mode_off_i`=0, `xm_en_i`=0), an idle controller that samples `int_req_i`=1 raises `int_gnt_o` in the next cycle. It does this without raising `br_o` or `bb_o`, and it ignores `br_i`, `bg_i` and `bb_i`.
- R4: Once `int_gnt_o` is high, it stays high until the edge at which `int_last_i`=1 is sampled. It is low in the cycle after that edge.
- R5: In internal-arbiter mode (`xm_en_i`=1, `arb_ext_i`=0), an idle controller that samples `br_i`=1 with `bb_i`=0 raises `bg_o` in the next cycle. The external request wins over an internal request sampled at the same edge.
- R6: In internal-arbiter mode, `bg_o` falls once `bb_i`=1 is sampled, and `ext_ack_o` is then high until `bb_i`=0 is sampled. An internal request is not granted while `bb_i` is high. An internal transfer in this mode drives `bb_o`=1.
- R7: In external-arbiter mode (`xm_en_i`=1, `arb_ext_i`=1), an internal request raises `br_o`. The grant follows only after an edge that samples `bg_i`=1 together with `bb_i`=0. `bb_o` is 1 for the whole transfer.
- R8: In external-arbiter mode, an idle controller that samples `bb_i`=1 raises `ext_ack_o` in the next cycle. It drops `ext_ack_o` after sampling `bb_i`=0.
- R9: The configuration inputs are taken over only at edges where the controller is idle. A change made during a transfer has no effect on that transfer's outputs.
- R10: `pins_free_o` is 1 exactly when the active mode is disabled or parked. It is 0 in both dual-master modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_off_i | input | 1 | Module disable |
| xm_en_i | input | 1 | External-master enable |
| arb_ext_i | input | 1 | 0: internal arbiter, 1: outside arbiter |
| int_req_i | input | 1 | Internal access request that hit a region |
| int_last_i | input | 1 | Last cycle of the granted internal transfer |
| br_i | input | 1 | Bus request from the other master |
| bg_i | input | 1 | Bus grant from the outside arbiter |
| bb_i | input | 1 | Bus busy driven by the other master |
| int_gnt_o | output | 1 | Grant to the internal requester |
| bb_o | output | 1 | Bus busy drive |
| br_o | output | 1 | Bus request to the outside arbiter |
| bg_o | output | 1 | Bus grant to the other master |
| ext_ack_o | output | 1 | External access into internal space acknowledged |
| pins_free_o | output | 1 | Arbitration pins free for another function |

## Verification
The assertions assume well-behaved neighbours. The internal requester holds `int_req_i` until it is granted and raises `int_last_i` only during a grant. In internal-arbiter mode, the other master raises `bb_i` only after it has seen `bg_o`. The stimulus sequences follow these rules: request and last-cycle pulses are driven only around grants, and busy is driven only after a grant or while idle in external-arbiter mode. Configuration is changed both while idle and in the middle of a transfer, which exercises the deferred mode take-over.

// File: rtl/ebarb_pkg.sv
// Shared types for the bus mode arbitration controller.
// Assumes at most two masters on the external bus.
package ebarb_pkg;

    typedef enum logic [1:0] {
        MD_OFF     = 2'd0,
        MD_PARK    = 2'd1,
        MD_ARB_INT = 2'd2,
        MD_ARB_EXT = 2'd3
    } bus_mode_t;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_REQ   = 3'd1,
        ST_OWN   = 3'd2,
        ST_XGNT  = 3'd3,
        ST_XBUSY = 3'd4
    } arb_state_t;

    // Map the three configuration bits onto an operating mode.
    function automatic bus_mode_t decode_mode(input logic off, input logic xm, input logic arb_sel);
        if (off)          return MD_OFF;
        else if (!xm)     return MD_PARK;
        else if (arb_sel) return MD_ARB_EXT;
        else              return MD_ARB_INT;
    endfunction

    // True when the mode uses the request, grant and busy pins.
    function automatic logic is_dual(input bus_mode_t m);
        return (m == MD_ARB_INT) || (m == MD_ARB_EXT);
    endfunction

endpackage

// File: rtl/ebarb_mode_sel.sv
// Mode holder: takes the configuration inputs over only while the
// controller is idle, so a running transfer keeps its mode.
// Assumes bus_idle_i comes from the arbitration state register.
module ebarb_mode_sel
    import ebarb_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      bus_idle_i,
    input  logic      off_i,
    input  logic      xm_i,
    input  logic      arb_sel_i,
    output bus_mode_t mode_eff_o,
    output bus_mode_t mode_q_o
);

    bus_mode_t mode_q;

    // Effective mode: fresh configuration when idle, held mode otherwise.
    always_comb begin
        mode_eff_o = bus_idle_i ? decode_mode(off_i, xm_i, arb_sel_i) : mode_q;
    end

    // Hold register for the active mode.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MD_OFF;
        else        mode_q <= mode_eff_o;
    end

    assign mode_q_o = mode_q;

endmodule

// File: rtl/ebarb_fsm.sv
// Arbitration state machine for one local and one remote master.
// Assumes int_req_i is held until granted and int_last_i only pulses
// during a grant.
module ebarb_fsm
    import ebarb_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  bus_mode_t mode_eff_i,
    input  bus_mode_t mode_q_i,
    input  logic      int_req_i,
    input  logic      int_last_i,
    input  logic      br_i,
    input  logic      bg_i,
    input  logic      bb_i,
    output logic      bus_idle_o,
    output logic      int_gnt_o,
    output logic      bb_o,
    output logic      br_o,
    output logic      bg_o,
    output logic      ext_ack_o
);

    arb_state_t state_q, state_d;

    // Next-state selection per state and mode.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                unique case (mode_eff_i)
                    MD_PARK: begin
                        if (int_req_i) state_d = ST_OWN;
                    end
                    MD_ARB_INT: begin
                        if (br_i && !bb_i)           state_d = ST_XGNT;
                        else if (int_req_i && !bb_i) state_d = ST_OWN;
                    end
                    MD_ARB_EXT: begin
                        if (bb_i)           state_d = ST_XBUSY;
                        else if (int_req_i) state_d = ST_REQ;
                    end
                    default: state_d = ST_IDLE;
                endcase
            end
            ST_REQ:   if (bg_i && !bb_i) state_d = ST_OWN;
            ST_OWN:   if (int_last_i)    state_d = ST_IDLE;
            ST_XGNT:  if (bb_i)          state_d = ST_XBUSY;
            ST_XBUSY: if (!bb_i)         state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output decode from the registered state and held mode.
    always_comb begin
        bus_idle_o = (state_q == ST_IDLE);
        int_gnt_o  = (state_q == ST_OWN);
        bb_o       = (state_q == ST_OWN) && is_dual(mode_q_i);
        br_o       = (state_q == ST_REQ);
        bg_o       = (state_q == ST_XGNT);
        ext_ack_o  = (state_q == ST_XBUSY);
    end

endmodule

// File: rtl/ebarb_ctrl.sv
// Top of the bus mode arbitration controller: joins the mode holder
// and the arbitration state machine, and flags free arbitration pins.
// Assumes all inputs are synchronous to clk.
module ebarb_ctrl
    import ebarb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_off_i,
    input  logic xm_en_i,
    input  logic arb_ext_i,
    input  logic int_req_i,
    input  logic int_last_i,
    input  logic br_i,
    input  logic bg_i,
    input  logic bb_i,
    output logic int_gnt_o,
    output logic bb_o,
    output logic br_o,
    output logic bg_o,
    output logic ext_ack_o,
    output logic pins_free_o
);

    bus_mode_t mode_eff;
    bus_mode_t mode_q;
    logic      bus_idle;

    ebarb_mode_sel u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_idle_i (bus_idle),
        .off_i      (mode_off_i),
        .xm_i       (xm_en_i),
        .arb_sel_i  (arb_ext_i),
        .mode_eff_o (mode_eff),
        .mode_q_o   (mode_q)
    );

    ebarb_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_eff_i (mode_eff),
        .mode_q_i   (mode_q),
        .int_req_i  (int_req_i),
        .int_last_i (int_last_i),
        .br_i       (br_i),
        .bg_i       (bg_i),
        .bb_i       (bb_i),
        .bus_idle_o (bus_idle),
        .int_gnt_o  (int_gnt_o),
        .bb_o       (bb_o),
        .br_o       (br_o),
        .bg_o       (bg_o),
        .ext_ack_o  (ext_ack_o)
    );

    // Pins are released whenever the held mode does not arbitrate.
    always_comb begin
        pins_free_o = !is_dual(mode_q);
    end

endmodule

// File: rtl/ebarb_ctrl_chk.sv
// Property checker for ebarb_ctrl, attached with bind below.
// Assumes the input rules listed in the brief.
module ebarb_ctrl_chk
    import ebarb_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      br_i,
    input logic      bg_i,
    input logic      bb_i,
    input logic      int_gnt_o,
    input logic      bb_o,
    input logic      br_o,
    input logic      bg_o,
    input logic      ext_ack_o,
    input logic      pins_free_o,
    input bus_mode_t mode_q
);

    // R2
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MD_OFF) |-> (!int_gnt_o && !bb_o && !br_o && !bg_o && !ext_ack_o));

    // R3
    park_no_arb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MD_PARK) |-> (!bb_o && !br_o && !bg_o && !ext_ack_o));

    // R5
    grant_on_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bg_o) |-> ($past(br_i) && !$past(bb_i)));

    // R6
    ack_ends_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ext_ack_o) |-> !$past(bb_i));

    // R6
    single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_gnt_o |-> (!ext_ack_o && !bg_o));

    // R7
    slave_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == MD_ARB_EXT) && $rose(int_gnt_o)) |-> ($past(br_o) && $past(bg_i) && !$past(bb_i)));

    // R9
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_gnt_o && $past(int_gnt_o)) |-> $stable(mode_q));

    // R10
    free_pins_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pins_free_o |-> (!bb_o && !br_o && !bg_o));

endmodule

bind ebarb_ctrl ebarb_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .br_i        (br_i),
    .bg_i        (bg_i),
    .bb_i        (bb_i),
    .int_gnt_o   (int_gnt_o),
    .bb_o        (bb_o),
    .br_o        (br_o),
    .bg_o        (bg_o),
    .ext_ack_o   (ext_ack_o),
    .pins_free_o (pins_free_o),
    .mode_q      (mode_q)
);

// File: tb/sim_ebarb_ctrl.sv
// Scoreboard bench: the driver pushes the expected outputs for each
// cycle; the monitor pops and compares after every rising edge.
module sim_ebarb_ctrl;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic off, xm, arb, req, last, br, bg, bb;
    logic int_gnt, bb_o, br_o, bg_o, ack, free;

    typedef struct {
        logic [5:0] exp;
        string      tag;
    } item_t;

    item_t sb_q[$];
    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ebarb_ctrl u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_off_i  (off),
        .xm_en_i     (xm),
        .arb_ext_i   (arb),
        .int_req_i   (req),
        .int_last_i  (last),
        .br_i        (br),
        .bg_i        (bg),
        .bb_i        (bb),
        .int_gnt_o   (int_gnt),
        .bb_o        (bb_o),
        .br_o        (br_o),
        .bg_o        (bg_o),
        .ext_ack_o   (ack),
        .pins_free_o (free)
    );

    // Driver: inputs {off,xm,arb,req,last,br,bg,bb};
    // expected outputs {gnt,bb,br,bg,ack,free} after the next edge.
    task automatic step(input logic [7:0] in, input logic [5:0] exp, input string tag);
        @(negedge clk);
        {off, xm, arb, req, last, br, bg, bb} = in;
        sb_q.push_back('{exp: exp, tag: tag});
    endtask

    // Monitor: compare outputs a short time after each rising edge.
    always @(posedge clk) begin
        #2;
        if (sb_q.size() > 0) begin
            item_t it;
            logic [5:0] got;
            it = sb_q.pop_front();
            got = {int_gnt, bb_o, br_o, bg_o, ack, free};
            compared++;
            if (got !== it.exp) begin
                mismatched++;
                $display("FAIL %s: got %b expected %b", it.tag, got, it.exp);
            end
        end
    end

    initial begin
        {off, xm, arb, req, last, br, bg, bb} = 8'b1000_0000;
        repeat (2) @(negedge clk);
        step(8'b1000_0000, 6'b000001, "R1 reset state");
        rst_n = 1'b1;
        // R2: disabled ignores everything
        step(8'b1001_0101, 6'b000001, "R2 off with requests");
        step(8'b1001_0111, 6'b000001, "R2 off stays quiet");
        // R10/R3: parked mode
        step(8'b0000_0000, 6'b000001, "R10 parked frees pins");
        step(8'b0001_0111, 6'b100001, "R3 parked grant ignores pins");
        step(8'b0001_0000, 6'b100001, "R4 grant held");
        step(8'b0001_1000, 6'b000001, "R4 grant ends after last");
        step(8'b0000_0000, 6'b000001, "R3 idle again");
        // R9: mode change during a transfer
        step(8'b0001_0000, 6'b100001, "R9 transfer starts");
        step(8'b0100_0000, 6'b100001, "R9 mode held mid transfer");
        step(8'b0100_1000, 6'b000001, "R9 still parked at end");
        step(8'b0100_0000, 6'b000000, "R10 dual mode claims pins");
        // R5/R6: internal arbiter
        step(8'b0101_0100, 6'b000100, "R5 external wins grant");
        step(8'b0101_0100, 6'b000100, "R5 grant waits for busy");
        step(8'b0101_0101, 6'b000010, "R6 busy seen, ack");
        step(8'b0101_0001, 6'b000010, "R6 internal waits on busy");
        step(8'b0101_0000, 6'b000000, "R6 release returns idle");
        step(8'b0101_0000, 6'b110000, "R6 internal transfer drives busy");
        step(8'b0100_1000, 6'b000000, "R4 internal transfer ends");
        step(8'b0101_0001, 6'b000000, "R6 no grant while busy");
        // R7/R8: outside arbiter
        step(8'b0110_0000, 6'b000000, "R10 slave mode pins used");
        step(8'b0111_0000, 6'b001000, "R7 request raised");
        step(8'b0111_0011, 6'b001000, "R7 grant while busy waits");
        step(8'b0111_0010, 6'b110000, "R7 grant with busy driven");
        step(8'b0110_1000, 6'b000000, "R7 transfer ends");
        step(8'b0110_0001, 6'b000010, "R8 remote access acked");
        step(8'b0110_0000, 6'b000000, "R8 ack drops");
        // R2: disable after dual mode
        step(8'b1101_0101, 6'b000001, "R2 off from slave mode");
        step(8'b1101_0101, 6'b000001, "R2 off still quiet");
        step(8'b1000_0000, 6'b000001, "R2 final idle");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(8 * 5000);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL ALL: watchdog expired, got hang expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule